// File: doc/BRIEF.md
# Tagged Word Queue with Acknowledged Head

This block is a small first-in first-out queue that takes 16-bit words from a register-write bus and passes them to a downstream sequencer. The two low bits of the bus address act as a sub-address. They select whether a write goes into the queue, and they are kept with the word as a routing tag. When the word leaves the queue, the tag comes out with it, so the consumer knows where to send it.

Every incoming word carries one odd-parity bit. A word with bad parity is never stored, and it raises a sticky fault flag. The oldest stored word moves into an output holding register. It stays there, with a valid flag, until the consumer pulses an acknowledge. Only after that does the next word move forward.

The pointer logic tells full from empty without an extra pointer bit. A one-bit record of whether the last pointer movement was a write or a read makes that choice when both pointers match.

Top module: `tagged_word_queue`

## Requirements
- R1: While `rst_n` is low, and after it is released, `q_empty` is 1 and `q_full`, `head_valid` and `parity_fault` are 0.
- R2: A write strobe is accepted only when `wr_sub` is 01, 10 or 11. A strobe with `wr_sub` = 00 stores nothing and changes no output.
- R3: The parity is good when the XOR of all 16 `wr_data` bits and `wr_par` equals 1. A strobe with bad parity stores nothing and sets `parity_fault`. `parity_fault` stays at 1 until reset.
- R4: Words come out in the order they were accepted. Each word appears on `head_data` together with the `wr_sub` value it was written with, which appears on `head_tag`.
- R5: The queue stores 16 words in addition to the held head word. `q_full` is 1 exactly when 16 words are stored. A write strobe while `q_full` is 1 is dropped.
- R6: `head_data` and `head_tag` stay stable while `head_valid` is 1 and `head_ack` is 0. An acknowledge clears `head_valid` on the next clock edge. The next stored word loads on the edge after that.
- R7: `head_valid` does not rise while no word is stored, and `head_ack` with `head_valid` low has no effect.
- R8: `q_empty` and `q_full` are never 1 together. Draining a full queue leaves `q_empty` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Bus write strobe |
| wr_sub | input | 2 | Low address bits: write qualifier and routing tag |
| wr_data | input | 16 | Bus write word |
| wr_par | input | 1 | Odd parity bit for `wr_data` |
| head_ack | input | 1 | Consumer acknowledge of the held word |
| head_valid | output | 1 | Holding register contains a word |
| head_data | output | 16 | Held word |
| head_tag | output | 2 | Routing tag of the held word |
| q_full | output | 1 | 16 words stored |
| q_empty | output | 1 | No word stored |
| parity_fault | output | 1 | Sticky bad-parity indication |

## Verification
A wrong last-operation flag shows at the ports within one cycle of the pointers meeting. After draining, the queue reports full, or after filling it reports empty, and words are then lost or repeated. A pointer that advances wrongly shows as a word out of order or a wrong tag at the next acknowledge. A holding register that reloads early shows as a change in `head_data` before the acknowledge. The bench fills the queue to its limit and drains it completely, so it compares every slot and the wrap of both pointers against the sequence it wrote.

// File: rtl/tq_pkg.sv
package tq_pkg;
  localparam int TQ_DATA_W = 16;
  localparam int TQ_TAG_W  = 2;

  typedef struct packed {
    logic [TQ_TAG_W-1:0]  tag;
    logic [TQ_DATA_W-1:0] data;
  } tq_entry_t;
endpackage

// File: rtl/tq_write_gate.sv
module tq_write_gate
  import tq_pkg::*;
(
  input  logic                 wr_en,
  input  logic [TQ_TAG_W-1:0]  wr_sub,
  input  logic [TQ_DATA_W-1:0] wr_data,
  input  logic                 wr_par,
  input  logic                 full,
  output logic                 push,
  output logic                 par_bad
);
  logic par_ok;
  logic sub_ok;

  always_comb begin
    par_ok  = ^{wr_par, wr_data};
    sub_ok  = (wr_sub != '0);
    par_bad = wr_en && !par_ok;
    push    = wr_en && par_ok && sub_ok && !full;
  end
endmodule

// File: rtl/tq_ptr_ctrl.sv
module tq_ptr_ctrl #(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             full,
  output logic             empty
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_ptr_nxt, rd_ptr_nxt;
  logic             last_wr, last_wr_nxt;
  logic             ptr_eq;

  always_comb begin
    ptr_eq = (wr_ptr == rd_ptr);
    full   = ptr_eq && last_wr;
    empty  = ptr_eq && !last_wr;

    wr_ptr_nxt = wr_ptr;
    if (push) wr_ptr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;

    rd_ptr_nxt = rd_ptr;
    if (pop) rd_ptr_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;

    last_wr_nxt = last_wr;
    if (push && !pop) last_wr_nxt = 1'b1;
    else if (pop && !push) last_wr_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      last_wr <= 1'b0;
    end else begin
      wr_ptr  <= wr_ptr_nxt;
      rd_ptr  <= rd_ptr_nxt;
      last_wr <= last_wr_nxt;
    end
  end
endmodule

// File: rtl/tq_store.sv
module tq_store
  import tq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             push,
  input  logic [PTR_W-1:0] wr_ptr,
  input  tq_entry_t        wr_entry,
  input  logic [PTR_W-1:0] rd_ptr,
  output tq_entry_t        rd_entry
);
  tq_entry_t slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    always_comb slot_we = push && (wr_ptr == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_we) slot[g] <= wr_entry;
    end
  end

  always_comb rd_entry = slot[rd_ptr];
endmodule

// File: rtl/tq_head_latch.sv
module tq_head_latch
  import tq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      q_empty,
  input  tq_entry_t rd_entry,
  input  logic      ack,
  output logic      pop,
  output logic      valid,
  output tq_entry_t held
);
  logic      valid_nxt;
  tq_entry_t held_nxt;
  logic      load;

  always_comb begin
    load      = !q_empty && !valid;
    pop       = load;
    valid_nxt = valid;
    held_nxt  = held;
    if (load) begin
      valid_nxt = 1'b1;
      held_nxt  = rd_entry;
    end else if (valid && ack) begin
      valid_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= valid_nxt;
  end

  always_ff @(posedge clk) begin
    if (load) held <= held_nxt;
  end
endmodule

// File: rtl/tagged_word_queue.sv
module tagged_word_queue
  import tq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [TQ_TAG_W-1:0]  wr_sub,
  input  logic [TQ_DATA_W-1:0] wr_data,
  input  logic                 wr_par,
  input  logic                 head_ack,
  output logic                 head_valid,
  output logic [TQ_DATA_W-1:0] head_data,
  output logic [TQ_TAG_W-1:0]  head_tag,
  output logic                 q_full,
  output logic                 q_empty,
  output logic                 parity_fault
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             push, pop, par_bad;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  tq_entry_t        wr_entry, rd_entry, held;
  logic             fault_q, fault_nxt;

  tq_write_gate u_gate (
    .wr_en   (wr_en),
    .wr_sub  (wr_sub),
    .wr_data (wr_data),
    .wr_par  (wr_par),
    .full    (q_full),
    .push    (push),
    .par_bad (par_bad)
  );

  tq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (push),
    .pop    (pop),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .full   (q_full),
    .empty  (q_empty)
  );

  always_comb begin
    wr_entry.tag  = wr_sub;
    wr_entry.data = wr_data;
  end

  tq_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .push     (push),
    .wr_ptr   (wr_ptr),
    .wr_entry (wr_entry),
    .rd_ptr   (rd_ptr),
    .rd_entry (rd_entry)
  );

  tq_head_latch u_head (
    .clk      (clk),
    .rst_n    (rst_n),
    .q_empty  (q_empty),
    .rd_entry (rd_entry),
    .ack      (head_ack),
    .pop      (pop),
    .valid    (head_valid),
    .held     (held)
  );

  always_comb fault_nxt = fault_q || par_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_nxt;
  end

  always_comb begin
    head_data    = held.data;
    head_tag     = held.tag;
    parity_fault = fault_q;
  end
endmodule

// File: rtl/tq_checker.sv
module tq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_sub,
  input logic [15:0] wr_data,
  input logic        wr_par,
  input logic        head_ack,
  input logic        head_valid,
  input logic [15:0] head_data,
  input logic [1:0]  head_tag,
  input logic        q_full,
  input logic        q_empty,
  input logic        parity_fault
);
  AST_NOT_FULL_AND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_full && q_empty)); // R8
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    parity_fault |=> parity_fault); // R3
  AST_BAD_PARITY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(^{wr_par, wr_data})) |=> parity_fault); // R3
  AST_HEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (head_valid && !head_ack) |=> (head_valid && $stable(head_data) && $stable(head_tag))); // R6
  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (head_valid && head_ack) |=> !head_valid); // R6
  AST_NO_LOAD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (q_empty && !head_valid) |=> !head_valid); // R7
  AST_TAG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    head_valid |-> (head_tag != 2'b00)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && head_valid && !head_ack) |=> q_full); // R5
endmodule

bind tagged_word_queue tq_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_sub       (wr_sub),
  .wr_data      (wr_data),
  .wr_par       (wr_par),
  .head_ack     (head_ack),
  .head_valid   (head_valid),
  .head_data    (head_data),
  .head_tag     (head_tag),
  .q_full       (q_full),
  .q_empty      (q_empty),
  .parity_fault (parity_fault)
);

// File: tb/tagged_word_queue_tb_top.sv
module tagged_word_queue_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sub = 2'b00;
  logic [15:0] wr_data = 16'h0;
  logic        wr_par = 1'b0;
  logic        head_ack = 1'b0;
  logic        head_valid, q_full, q_empty, parity_fault;
  logic [15:0] head_data;
  logic [1:0]  head_tag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tagged_word_queue dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sub(wr_sub),
    .wr_data(wr_data), .wr_par(wr_par), .head_ack(head_ack),
    .head_valid(head_valid), .head_data(head_data), .head_tag(head_tag),
    .q_full(q_full), .q_empty(q_empty), .parity_fault(parity_fault)
  );

  // Vector: {parity_good, sub[1:0], data[15:0]}
  localparam logic [18:0] VEC [6] = '{
    {1'b1, 2'b01, 16'hA001},
    {1'b1, 2'b10, 16'hB002},
    {1'b1, 2'b00, 16'hC003},
    {1'b1, 2'b11, 16'hD004},
    {1'b0, 2'b01, 16'hE005},
    {1'b1, 2'b10, 16'hF006}
  };

  logic [17:0] exp_q [64];
  int exp_n;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0; head_ack = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_word(input logic [1:0] sub, input logic [15:0] d, input bit good);
    @(negedge clk);
    wr_en = 1'b1; wr_sub = sub; wr_data = d;
    wr_par = good ? ~(^d) : (^d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drain_one(input logic [17:0] exp, input string req);
    int n = 0;
    while (!head_valid && n < 20) begin @(negedge clk); n++; end
    chk(head_valid, req, 32'(head_valid), 32'h1);
    chk({head_tag, head_data} == exp, req, 32'({head_tag, head_data}), 32'(exp));
    head_ack = 1'b1;
    @(negedge clk);
    head_ack = 1'b0;
    chk(!head_valid, "R6 ack clears", 32'(head_valid), 32'h0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state, R7 no spurious load
    @(negedge clk);
    chk(q_empty && !q_full && !head_valid && !parity_fault, "R1 during reset",
        {28'h0, q_empty, q_full, head_valid, parity_fault}, 32'h8);
    do_reset();
    repeat (3) @(negedge clk);
    chk(q_empty && !q_full && !head_valid && !parity_fault, "R1 after reset",
        {28'h0, q_empty, q_full, head_valid, parity_fault}, 32'h8);
    head_ack = 1'b1; @(negedge clk); head_ack = 1'b0; @(negedge clk);
    chk(!head_valid && q_empty, "R7 stray ack", 32'(head_valid), 32'h0);

    // Table walk: R2 sub-address gate, R3 parity, R4 tag and order
    exp_n = 0;
    for (int i = 0; i < 6; i++) begin
      write_word(VEC[i][17:16], VEC[i][15:0], VEC[i][18]);
      if (VEC[i][18] && VEC[i][17:16] != 2'b00) begin
        exp_q[exp_n] = VEC[i][17:0];
        exp_n++;
      end
      if (!VEC[i][18])
        chk(parity_fault, "R3 bad parity flags", 32'(parity_fault), 32'h1);
    end
    for (int i = 0; i < exp_n; i++) drain_one(exp_q[i], "R4 order/tag (R2 R3 drop)");
    repeat (3) @(negedge clk);
    chk(!head_valid && q_empty, "R2 no extra word", {30'h0, head_valid, q_empty}, 32'h1);
    chk(parity_fault, "R3 sticky", 32'(parity_fault), 32'h1);

    // R6 hold until acknowledge
    write_word(2'b11, 16'h1234, 1'b1);
    write_word(2'b01, 16'h5678, 1'b1);
    repeat (5) @(negedge clk);
    chk(head_valid && {head_tag, head_data} == {2'b11, 16'h1234}, "R6 held",
        32'({head_tag, head_data}), 32'({2'b11, 16'h1234}));
    drain_one({2'b11, 16'h1234}, "R6 first");
    @(negedge clk);
    chk(head_valid && head_data == 16'h5678, "R6 reload", 32'(head_data), 32'h5678);
    drain_one({2'b01, 16'h5678}, "R6 second");

    // Reset clears sticky fault (R1)
    do_reset();
    chk(!parity_fault && q_empty, "R1 reset clears fault", 32'(parity_fault), 32'h0);

    // R5 fill to full, overflow dropped, R8 drain back to empty
    exp_n = 0;
    for (int i = 0; i < 17; i++) begin
      logic [1:0] s;
      s = 2'(i % 3 + 1);
      write_word(s, 16'h1000 + 16'(i), 1'b1);
      exp_q[exp_n] = {s, 16'h1000 + 16'(i)};
      exp_n++;
      if (i == 15) chk(!q_full, "R5 not full at 15 stored", 32'(q_full), 32'h0);
    end
    chk(q_full && !q_empty, "R5 full at 16 stored", {30'h0, q_full, q_empty}, 32'h2);
    write_word(2'b01, 16'hDEAD, 1'b1);
    chk(q_full, "R5 stays full", 32'(q_full), 32'h1);
    for (int i = 0; i < exp_n; i++) drain_one(exp_q[i], "R5 drain order");
    repeat (3) @(negedge clk);
    chk(q_empty && !q_full && !head_valid, "R8 empty after drain",
        {29'h0, q_empty, q_full, head_valid}, 32'h4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule